// File: doc/BRIEF.md
# I/O Page-Table-Entry Translation Cache

This block holds I/O page-table entries for a DMA address translation unit. It is organised as 4 ways by 64 sets. A lookup presents a segment-table entry and an I/O address. From these the block forms the address where the page-table entry would live in memory. It folds that address into a set index with a fixed XOR pattern and takes a comparison key from two separate bit ranges of the same address. One cycle later it answers with hit or miss and the cached 64-bit entry.

Filling is a two-step sequence. A data write first loads a 64-bit holding register. A tag write then places a tag word at a chosen index, and the holding register's contents go into the same slot. In the normal 4-way mode the block picks the way itself. It uses the lowest invalid way if there is one, and otherwise rotates through the ways of that set. A direct-mapped mode turns the same storage into 256 single entries addressed by an 8-bit index. In that mode the fill index picks the slot outright, and a tag write with the valid bit clear removes the entry.

Top module: `iopte_cache`

## Requirements
- R1: The entry address is 42 bits wide. It is formed as `{seg[41:12], 12'b0}` plus an offset. The offset is the page number shifted left by 3 and masked to bits 18:3. The page number is `ioaddr[27:0]` shifted right by `10 + 2*seg[3:0]`.
- R2: In 4-way mode the set index bit k (k = 0..5) equals entry-address bit (3+k) XOR entry-address bit (17-k).
- R3: A tag word is 34 bits. Bit 33 is the valid flag, bits 32:9 carry entry-address bits 41:18, and bits 8:0 carry entry-address bits 11:3. A lookup compares its computed bits 32:0 against stored tags.
- R4: Every cycle with `lk_valid` high produces exactly one response on the following cycle, and no other cycle does. `rsp_hit` is high only when a valid way of the addressed set holds an equal tag. `rsp_data` is that way's entry on a hit and zero on a miss.
- R5: `fill_data_we` loads the holding register. `fill_tag_we` stores `fill_tag` together with the holding register's current contents into the target slot. A data write in the same cycle as a tag write only affects later fills.
- R6: In 4-way mode a tag write goes to the lowest-numbered invalid way of set `fill_index[5:0]`. If all four ways are valid, it goes to the way named by that set's round-robin pointer, which then advances by one. Pointers start at way 0 after reset.
- R7: With `dm_mode` high, the lookup index is `{ea[15:14], hash6}`. Index bits 7:6 name the way and bits 5:0 the set, and only that one slot is compared. A fill writes exactly the slot `fill_index` names.
- R8: A tag write with bit 33 clear leaves its target slot invalid, so a later lookup of that slot misses.
- R9: A lookup and a tag write in the same cycle are ordered so that the lookup sees the contents from before that write.
- R10: A synchronous active-low reset clears all valid flags, the round-robin pointers, the holding register and the response outputs.
- R11: In 4-way mode, when more than one way of a set matches, the lowest-numbered matching way supplies the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dm_mode | input | 1 | 1 = direct-mapped 8-bit indexing, 0 = 4-way hashed |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_seg | input | 64 | Segment-table entry: table base in 41:12, page-size code in 3:0 |
| lk_ioaddr | input | 32 | I/O address to translate |
| fill_data_we | input | 1 | Load the holding register |
| fill_data | input | 64 | Page-table entry value for the holding register |
| fill_tag_we | input | 1 | Write a tag (and the holding register) to the target slot |
| fill_index | input | 8 | Fill index: set in 5:0, way in 7:6 in direct-mapped mode |
| fill_tag | input | 34 | Tag word, valid in bit 33 |
| rsp_valid | output | 1 | Response for the lookup of the previous cycle |
| rsp_hit | output | 1 | That lookup hit |
| rsp_data | output | 64 | Cached entry on a hit, zero otherwise |

## Verification
A lookup and a tag write can land in the same cycle, and this can also happen on the very slot the lookup addresses. The bench provokes this with a directed case: a fill and a lookup of the same address in one cycle, followed by the same lookup repeated. It also provokes it throughout a long random phase that draws both from a small address pool. A behavioural reference model applies the lookup against the old contents before applying the fill, and the design's response is compared with it on every clock. A second collision, a data write in the same cycle as a tag write, is judged the same way against the rule that the tag write stores the previously held value.

// File: rtl/iopte_pkg.sv
// Package: shared constants for the I/O page-table-entry cache.
// Assumes the fixed entry-address layout: 42-bit entry address, 34-bit tag,
// 64-bit cached entry, 6-bit hashed set index, 8-bit direct-mapped index.
package iopte_pkg;
    localparam int EA_W      = 42;            // entry-address width
    localparam int TAG_W     = 34;            // tag word incl. valid flag
    localparam int KEY_W     = TAG_W - 1;     // compared part of the tag
    localparam int ENTRY_W   = 64;            // cached page-table entry
    localparam int SEG_W     = 64;            // segment-table entry
    localparam int IOA_W     = 32;            // I/O address
    localparam int HASH_W    = 6;             // set index width
    localparam int WAYS      = 4;
    localparam int WAY_W     = $clog2(WAYS);
    localparam int SETS      = 1 << HASH_W;
    localparam int DMI_W     = HASH_W + WAY_W; // direct-mapped index
    localparam int PGN_BITS  = 28;            // I/O address bits translated
    localparam int OFF_LO    = 3;             // entry offset low bit
    localparam int OFF_HI    = 18;            // entry offset high bit
    localparam int PAGE_SH   = 12;            // table base alignment
    localparam int FOLD_HI   = 17;            // top bit of the XOR fold

    typedef logic [KEY_W-1:0]   key_t;
    typedef logic [ENTRY_W-1:0] entry_t;
endpackage

// File: rtl/iopte_addr_gen.sv
// Module: iopte_addr_gen
// Purely combinational. Forms the page-table-entry address from a segment
// entry and an I/O address, then folds it into the hashed set index, the
// direct-mapped index and the comparison key (R1, R2, R3, R7).
// Assumes the page-size code sits in seg_i[3:0] and the table base in 41:12.
module iopte_addr_gen
    import iopte_pkg::*;
(
    input  logic [SEG_W-1:0] seg_i,
    input  logic [IOA_W-1:0] ioa_i,
    output logic [DMI_W-1:0] idx_o,
    output key_t             key_o
);
    localparam int OFF_W = OFF_HI - OFF_LO + 1;

    logic [6:0]          shamt;
    logic [PGN_BITS-1:0] pgnum;
    logic [EA_W-1:0]     base;
    logic [EA_W-1:0]     offset;
    logic [EA_W-1:0]     ea;

    // Page number and entry address (R1).
    always_comb begin
        shamt  = 7'd10 + {2'b00, seg_i[3:0], 1'b0};
        pgnum  = ioa_i[PGN_BITS-1:0] >> shamt;
        base   = {seg_i[EA_W-1:PAGE_SH], {PAGE_SH{1'b0}}};
        offset = {{(EA_W-OFF_HI-1){1'b0}}, pgnum[OFF_W-1:0], {OFF_LO{1'b0}}};
        ea     = base + offset;
    end

    // XOR fold: low run of bits against a reversed high run (R2).
    for (genvar k = 0; k < HASH_W; k++) begin : g_fold
        assign idx_o[k] = ea[OFF_LO + k] ^ ea[FOLD_HI - k];
    end

    // Direct-mapped extension bits (R7).
    assign idx_o[DMI_W-1:HASH_W] = ea[15:14];

    // Comparison key from two separate ranges (R3).
    assign key_o = {ea[EA_W-1:OFF_HI], ea[PAGE_SH-1:OFF_LO]};

    logic unused_addr_bits;
    assign unused_addr_bits = ^{seg_i[SEG_W-1:EA_W], seg_i[PAGE_SH-1:4],
                                ioa_i[IOA_W-1:PGN_BITS], pgnum[PGN_BITS-1:OFF_W],
                                ea[OFF_LO-1:0]};
endmodule

// File: rtl/iopte_victim.sv
// Module: iopte_victim
// Combinational way chooser for one set. It prefers the lowest invalid way
// and otherwise returns the set's round-robin pointer (R6).
// Assumes WAYS is a power of two so the pointer wraps on its own.
module iopte_victim #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  vld_i,
    input  logic [WAY_W-1:0] rr_i,
    output logic [WAY_W-1:0] way_o,
    output logic             full_o
);
    // Scan from the top so the lowest invalid way wins.
    always_comb begin
        full_o = &vld_i;
        way_o  = rr_i;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_i[w]) way_o = WAY_W'(w);
        end
    end
endmodule

// File: rtl/iopte_store.sv
// Module: iopte_store
// Tag, valid and entry arrays with the lookup compare, the fill path,
// the holding register and the registered response.
// Assumes the index and key are already computed. A lookup reads the state
// from before any write in the same cycle (R9).
module iopte_store
    import iopte_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dm_mode_i,
    input  logic             lk_valid_i,
    input  logic [DMI_W-1:0] lk_idx_i,
    input  key_t             lk_key_i,
    input  logic             fill_data_we_i,
    input  entry_t           fill_data_i,
    input  logic             fill_tag_we_i,
    input  logic [DMI_W-1:0] fill_index_i,
    input  logic [TAG_W-1:0] fill_tag_i,
    output logic             rsp_valid_o,
    output logic             rsp_hit_o,
    output entry_t           rsp_data_o
);
    logic [WAYS-1:0]  vld_q [SETS];
    key_t             key_q [WAYS][SETS];
    entry_t           dat_q [WAYS][SETS];
    logic [WAY_W-1:0] rr_q  [SETS];
    entry_t           hold_q;

    logic [HASH_W-1:0] lk_set;
    logic [WAYS-1:0]   match;
    logic              hit;
    logic [WAY_W-1:0]  sel;

    logic [HASH_W-1:0] f_set;
    logic [WAY_W-1:0]  vic_way;
    logic              vic_full;
    logic [WAY_W-1:0]  f_way;
    logic              f_replace;

    assign lk_set = lk_idx_i[HASH_W-1:0];

    // Per-way compare; direct mode only lets the named way take part (R4, R7).
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = vld_q[lk_set][w]
                       && (key_q[w][lk_set] == lk_key_i)
                       && (!dm_mode_i || (lk_idx_i[DMI_W-1:HASH_W] == WAY_W'(w)));
    end

    // Lowest matching way supplies the data (R11).
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit = 1'b1;
                sel = WAY_W'(w);
            end
        end
    end

    assign f_set = fill_index_i[HASH_W-1:0];

    iopte_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .vld_i  (vld_q[f_set]),
        .rr_i   (rr_q[f_set]),
        .way_o  (vic_way),
        .full_o (vic_full)
    );

    // Fill target: index bits in direct mode, chooser otherwise (R6, R7).
    assign f_way     = dm_mode_i ? fill_index_i[DMI_W-1:HASH_W] : vic_way;
    assign f_replace = !dm_mode_i && vic_full;

    // Control state: valid flags, pointers, holding register, response (R5, R6, R8, R10).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                rr_q[s]  <= '0;
            end
            hold_q      <= '0;
            rsp_valid_o <= 1'b0;
            rsp_hit_o   <= 1'b0;
            rsp_data_o  <= '0;
        end else begin
            if (fill_tag_we_i) begin
                vld_q[f_set][f_way] <= fill_tag_i[TAG_W-1];
                if (f_replace) rr_q[f_set] <= rr_q[f_set] + 1'b1;
            end
            if (fill_data_we_i) hold_q <= fill_data_i;
            rsp_valid_o <= lk_valid_i;
            rsp_hit_o   <= lk_valid_i && hit;
            rsp_data_o  <= (lk_valid_i && hit) ? dat_q[sel][lk_set] : '0;
        end
    end

    // Key and entry payload; need no reset because valid flags gate them.
    always_ff @(posedge clk) begin
        if (fill_tag_we_i) begin
            key_q[f_way][f_set] <= fill_tag_i[KEY_W-1:0];
            dat_q[f_way][f_set] <= hold_q;
        end
    end
endmodule

// File: rtl/iopte_cache.sv
// Module: iopte_cache (top)
// Hashed, 4-way set-associative cache of I/O page-table entries with a
// direct-mapped mode. A lookup is answered one cycle later. Fills are a
// holding-register write followed by a tag write.
// Assumes one lookup per cycle at most and a static dm_mode while in use.
module iopte_cache
    import iopte_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dm_mode,
    input  logic               lk_valid,
    input  logic [SEG_W-1:0]   lk_seg,
    input  logic [IOA_W-1:0]   lk_ioaddr,
    input  logic               fill_data_we,
    input  logic [ENTRY_W-1:0] fill_data,
    input  logic               fill_tag_we,
    input  logic [DMI_W-1:0]   fill_index,
    input  logic [TAG_W-1:0]   fill_tag,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [ENTRY_W-1:0] rsp_data
);
    logic [DMI_W-1:0] lk_idx;
    key_t             lk_key;

    // Address, index and key generation for the lookup.
    iopte_addr_gen u_gen (
        .seg_i (lk_seg),
        .ioa_i (lk_ioaddr),
        .idx_o (lk_idx),
        .key_o (lk_key)
    );

    // Storage, fill path and response.
    iopte_store u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .dm_mode_i      (dm_mode),
        .lk_valid_i     (lk_valid),
        .lk_idx_i       (lk_idx),
        .lk_key_i       (lk_key),
        .fill_data_we_i (fill_data_we),
        .fill_data_i    (fill_data),
        .fill_tag_we_i  (fill_tag_we),
        .fill_index_i   (fill_index),
        .fill_tag_i     (fill_tag),
        .rsp_valid_o    (rsp_valid),
        .rsp_hit_o      (rsp_hit),
        .rsp_data_o     (rsp_data)
    );
endmodule

// File: rtl/iopte_cache_chk.sv
// Module: iopte_cache_chk
// Protocol checker bound to iopte_cache. It watches the port timing of the
// response and tracks whether any valid tag was ever written since reset.
module iopte_cache_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              fill_tag_we,
    input logic              fill_tag_vld,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [DATA_W-1:0] rsp_data
);
    logic empty_q;

    // Set at reset; cleared once a tag with its valid flag is written.
    always_ff @(posedge clk) begin
        if (!rst_n)                          empty_q <= 1'b1;
        else if (fill_tag_we && fill_tag_vld) empty_q <= 1'b0;
    end

    assert_lookup_answered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    assert_no_spurious_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    assert_hit_in_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_data == '0));

    assert_empty_misses_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_q && lk_valid) |=> !rsp_hit);
endmodule

bind iopte_cache iopte_cache_chk #(.DATA_W(64)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .fill_tag_we  (fill_tag_we),
    .fill_tag_vld (fill_tag[33]),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_data     (rsp_data)
);

// File: tb/tb_iopte_cache.sv
module tb_iopte_cache;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        dm_mode;
    logic        lk_valid;
    logic [63:0] lk_seg;
    logic [31:0] lk_ioaddr;
    logic        fill_data_we;
    logic [63:0] fill_data;
    logic        fill_tag_we;
    logic [7:0]  fill_index;
    logic [33:0] fill_tag;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [63:0] rsp_data;

    always #5 clk = ~clk;

    iopte_cache dut (.*);

    int    nchk = 0;
    int    nerr = 0;
    string phase = "R10";
    bit    cmp_on = 1'b0;

    // ---------------- reference model ----------------
    logic        mv [4][64];
    logic [32:0] mk [4][64];
    logic [63:0] md [4][64];
    int          mrr [64];
    logic [63:0] mhold;
    logic        e_valid, e_hit;
    logic [63:0] e_data;

    function automatic logic [63:0] ref_ea(input logic [63:0] seg, input logic [31:0] io);
        logic [63:0] base, pn;
        base = seg & 64'h0000_03FF_FFFF_F000;
        pn   = ({32'h0, io} & 64'h0FFF_FFFF) >> (10 + 2 * int'(seg[3:0]));
        return (base + ((pn << 3) & 64'h7_FFF8)) & 64'h3FF_FFFF_FFFF;
    endfunction

    function automatic logic [7:0] ref_idx(input logic [63:0] seg, input logic [31:0] io);
        logic [63:0] ea, r;
        ea = ref_ea(seg, io);
        r  = ((ea >> 3) & 63) ^ ((ea >> 17) & 1) ^ ((ea >> 15) & 2) ^ ((ea >> 13) & 4)
           ^ ((ea >> 11) & 8) ^ ((ea >> 9) & 16) ^ ((ea >> 7) & 32);
        r  = r | (((ea >> 14) & 3) << 6);
        return r[7:0];
    endfunction

    function automatic logic [32:0] ref_key(input logic [63:0] seg, input logic [31:0] io);
        logic [63:0] ea, r;
        ea = ref_ea(seg, io);
        r  = (((ea >> 18) & 64'hFF_FFFF) << 9) | ((ea >> 3) & 64'h1FF);
        return r[32:0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < 4; w++) for (int s = 0; s < 64; s++) mv[w][s] = 1'b0;
            for (int s = 0; s < 64; s++) mrr[s] = 0;
            mhold = '0; e_valid = 0; e_hit = 0; e_data = '0;
        end else begin
            logic h; logic [63:0] d; int set, w;
            h = 0; d = '0;
            if (lk_valid) begin
                logic [7:0] li; logic [32:0] lk;
                li = ref_idx(lk_seg, lk_ioaddr); lk = ref_key(lk_seg, lk_ioaddr);
                set = li % 64;
                if (dm_mode) begin
                    w = li / 64;
                    if (mv[w][set] && mk[w][set] == lk) begin h = 1; d = md[w][set]; end
                end else begin
                    for (int ww = 3; ww >= 0; ww--)
                        if (mv[ww][set] && mk[ww][set] == lk) begin h = 1; d = md[ww][set]; end
                end
            end
            if (fill_tag_we) begin
                set = fill_index % 64;
                if (dm_mode) w = fill_index / 64;
                else begin
                    w = -1;
                    for (int ww = 3; ww >= 0; ww--) if (!mv[ww][set]) w = ww;
                    if (w < 0) begin w = mrr[set]; mrr[set] = (mrr[set] + 1) % 4; end
                end
                mv[w][set] = fill_tag[33]; mk[w][set] = fill_tag[32:0]; md[w][set] = mhold;
            end
            if (fill_data_we) mhold = fill_data;
            e_valid = lk_valid; e_hit = h; e_data = d;
        end
    end

    // Compare with the model on every falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            nchk++;
            if (rsp_valid !== e_valid || rsp_hit !== e_hit || rsp_data !== e_data) begin
                nerr++;
                $display("FAIL %s: v/h/d=%0b/%0b/%h expected %0b/%0b/%h", phase,
                         rsp_valid, rsp_hit, rsp_data, e_valid, e_hit, e_data);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk);
        lk_valid = 0; fill_data_we = 0; fill_tag_we = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; lk_valid = 0; fill_data_we = 0; fill_tag_we = 0;
        repeat (2) @(negedge clk);
        nchk++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_data !== '0) begin
            nerr++;
            $display("FAIL R10: reset v/h/d=%0b/%0b/%h expected 0/0/0", rsp_valid, rsp_hit, rsp_data);
        end
        rst_n = 1;
    endtask

    task automatic look(input logic [63:0] s, input logic [31:0] io);
        lk_valid = 1; lk_seg = s; lk_ioaddr = io;
    endtask

    task automatic put_data(input logic [63:0] d);
        fill_data_we = 1; fill_data = d;
    endtask

    task automatic put_tag(input logic [7:0] i, input logic [33:0] t);
        fill_tag_we = 1; fill_index = i; fill_tag = t;
    endtask

    task automatic expect_rsp(input logic eh, input logic [63:0] ed, input string req);
        nchk++;
        if (rsp_valid !== 1'b1 || rsp_hit !== eh || rsp_data !== ed) begin
            nerr++;
            $display("FAIL %s: v/h/d=%0b/%0b/%h expected 1/%0b/%h", req,
                     rsp_valid, rsp_hit, rsp_data, eh, ed);
        end
    endtask

    localparam logic [63:0] SEG_A = 64'h0000_0100_0000_0007; // 16M pages
    localparam logic [31:0] IO_A  = 32'h0300_0000;            // idx 3, tag 2_8000_0003
    localparam logic [63:0] SEG_B = 64'h0000_0000_0000_0001; // 4K pages
    localparam logic [31:0] IO_B  = 32'h0ABC_D000;            // idx 27/67, tag 2_0000_03CD

    logic [63:0] pseg [16];
    logic [31:0] pio  [16];

    initial begin
        #2_000_000;
        nchk++; nerr++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        rst_n = 0; dm_mode = 0; lk_valid = 0; lk_seg = '0; lk_ioaddr = '0;
        fill_data_we = 0; fill_data = '0; fill_tag_we = 0; fill_index = '0; fill_tag = '0;
        @(posedge clk);
        cmp_on = 1;
        do_reset();

        // R1 R3: hand-computed 16M case in 4-way mode
        phase = "R1";
        tick(); put_data(64'hC000_0100_0000_048A);
        tick(); put_tag(8'h03, 34'h2_8000_0003);
        tick(); look(SEG_A, IO_A);
        tick(); expect_rsp(1, 64'hC000_0100_0000_048A, "R1");
        look(SEG_A, 32'h0400_0000);
        tick(); expect_rsp(0, '0, "R3");

        // R2: hand-computed 4K case, set 0x27
        phase = "R2";
        put_data(64'h4000_0000_1234_5001);
        tick(); put_tag(8'h27, 34'h2_0000_03CD);
        tick(); look(SEG_B, IO_B);
        tick(); expect_rsp(1, 64'h4000_0000_1234_5001, "R2");

        // R7 R8: direct-mapped indexing and invalidation
        phase = "R7";
        do_reset(); dm_mode = 1;
        tick(); put_data(64'h8000_0000_0000_0777);
        tick(); put_tag(8'h27, 34'h2_0000_03CD);   // wrong way for this address
        tick(); look(SEG_B, IO_B);
        tick(); expect_rsp(0, '0, "R7");
        put_data(64'h8000_0000_0000_0999);
        tick(); put_tag(8'h67, 34'h2_0000_03CD);
        tick(); look(SEG_B, IO_B);
        tick(); expect_rsp(1, 64'h8000_0000_0000_0999, "R7");
        phase = "R8";
        put_tag(8'h67, 34'h0_0000_03CD);
        tick(); look(SEG_B, IO_B);
        tick(); expect_rsp(0, '0, "R8");

        // R5: data write in the same cycle as the tag write
        phase = "R5";
        do_reset(); dm_mode = 0;
        tick(); put_data(64'h1111);
        tick(); put_data(64'h2222); put_tag(8'h03, 34'h2_8000_0003);
        tick(); look(SEG_A, IO_A);
        tick(); expect_rsp(1, 64'h1111, "R5");

        // R11: duplicate tags in one set, lowest way wins
        phase = "R11";
        do_reset();
        tick(); put_data(64'hAAAA);
        tick(); put_tag(8'h03, 34'h2_8000_0003);
        tick(); put_data(64'hBBBB);
        tick(); put_tag(8'h03, 34'h2_8000_0003);
        tick(); look(SEG_A, IO_A);
        tick(); expect_rsp(1, 64'hAAAA, "R11");

        // R6: six fills into one set, round-robin after the set is full
        phase = "R6";
        do_reset();
        for (int k = 1; k <= 6; k++) begin
            tick(); put_data(64'(k));
            tick(); put_tag(ref_idx((64'(k) << 18) | 7, IO_A),
                            {1'b1, ref_key((64'(k) << 18) | 7, IO_A)});
        end
        tick(); look((64'd1 << 18) | 7, IO_A);
        tick(); expect_rsp(0, '0, "R6");
        look((64'd2 << 18) | 7, IO_A);
        tick(); expect_rsp(0, '0, "R6");
        look((64'd3 << 18) | 7, IO_A);
        tick(); expect_rsp(1, 64'd3, "R6");
        look((64'd5 << 18) | 7, IO_A);
        tick(); expect_rsp(1, 64'd5, "R6");
        look((64'd6 << 18) | 7, IO_A);
        tick(); expect_rsp(1, 64'd6, "R6");

        // R9: lookup and fill of the same address in one cycle
        phase = "R9";
        do_reset();
        tick(); put_data(64'h9999);
        tick(); put_tag(8'h03, 34'h2_8000_0003); look(SEG_A, IO_A);
        tick(); expect_rsp(0, '0, "R9");
        look(SEG_A, IO_A);
        tick(); expect_rsp(1, 64'h9999, "R9");

        // R4: random traffic from a small pool, both modes
        for (int p = 0; p < 16; p++) begin
            pseg[p] = (64'($urandom % 8) << 18) | 64'(2 * ($urandom % 4) + 1);
            pio[p]  = $urandom;
        end
        for (int m = 0; m < 2; m++) begin
            phase = (m == 0) ? "R4" : "R7";
            do_reset(); dm_mode = m[0];
            for (int c = 0; c < 1500; c++) begin
                int p;
                tick();
                p = $urandom % 16;
                if ($urandom % 2 == 0) look(pseg[p], pio[p]);
                if ($urandom % 3 == 0) put_data({$urandom, $urandom});
                if ($urandom % 3 == 0) begin
                    p = $urandom % 16;
                    put_tag(ref_idx(pseg[p], pio[p]),
                            {($urandom % 8 != 0), ref_key(pseg[p], pio[p])});
                end
            end
        end
        tick(); tick();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule